// File: doc/BRIEF.md
# Shared Counter with Per-Core Compare Timers

This block keeps one free-running 64-bit count that every processor core in a cluster sees, and gives each core its own comparator, auto-increment step, status flag and interrupt line. A prescaler divides the input clock, so the count moves up once every (P + 1) clock cycles while the shared timer enable is set. Each core arms its own comparator. When the count reaches or passes the comparator, the core's status flag sets. If that core has enabled interrupts, its interrupt line goes high.

Software reaches the block through a simple 32-bit register port. A core-ID input picks which core's banked registers an access addresses. Reads return data one cycle after the request. A core can run periodic interrupts without software help by turning on auto-increment: each time the comparator is met, the block moves the comparator forward by the increment until it lies beyond the count.

Top module: `glob_cmp_timer`

## Requirements
- R1: The 64-bit count is reached as two 32-bit halves: byte offset 0x00 holds the low word and 0x04 the high word. A value loaded into both halves while the timer is stopped reads back unchanged.
- R2: While the timer enable (control bit 0) is set, the count rises by exactly one every P + 1 clock cycles, where P is control bits 15:8. Every control write restarts the prescale phase.
- R3: While the timer enable is clear, the count holds its value.
- R4: A write to either count half while the timer is enabled leaves the count unchanged and raises `cnt_wr_err` for one cycle. The same write with the timer stopped does not raise it.
- R5: A core's compare event happens in every cycle in which the timer is enabled, that core's compare enable (control bit 1) is set, and the count is greater than or equal to its 64-bit comparator (0x10 low, 0x14 high). The event sets that core's status bit 0 at offset 0x0C.
- R6: With auto-increment (control bit 3) set and a nonzero increment (offset 0x18), every compare event adds the increment to the comparator. The comparator therefore settles on the first value comparator + k·increment that is above the count. With a zero increment the comparator is left alone.
- R7: `irq[i]` is a registered copy of core i's status bit ANDed with its interrupt enable (control bit 2). Cores do not affect each other.
- R8: The status register clears on write-one: writing 1 to bit 0 clears it unless a compare event happens in the same cycle. Writing 0 has no effect.
- R9: A control read returns the shared bits (0 and 15:8) ORed with the addressed core's banked bits (1 to 3). A control write from any core updates the shared bits.
- R10: Read data appears on `acc_rdata` one cycle after the request. Offsets with no register, such as 0x1C, read as zero.
- R11: A synchronous reset clears the count, the control bits, every comparator, increment, status flag and interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_core | input | CORE_W | Core whose bank is addressed |
| acc_addr | input | AW | Byte offset within the window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the request |
| cnt_wr_err | output | 1 | One-cycle pulse for a dropped count write |
| irq | output | N_CORES | Per-core interrupt lines |

## Verification
Assertions check on every cycle the following: the count steps by exactly one on a prescaler tick, and holds otherwise, whether the timer is stopped or running. The prescale phase never passes its limit. A compare condition always leads to a set status flag. Each auto-increment step moves the comparator by exactly the increment. An interrupt line is high only after its status and enable were both set.

Only the bench scenarios can show the following:
- the measured count rate for a chosen prescale;
- the exact value the comparator settles on after a catch-up;
- write-one-to-clear, and that writing 0 leaves the status set;
- the merged control readback per core;
- that the cores stay independent;
- the zero returned for an unmapped offset.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [AW-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [AW-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [AW-1:0] OFS_CTL    = 5'h08;
  localparam logic [AW-1:0] OFS_STAT   = 5'h0C;
  localparam logic [AW-1:0] OFS_CMP_LO = 5'h10;
  localparam logic [AW-1:0] OFS_CMP_HI = 5'h14;
  localparam logic [AW-1:0] OFS_INC    = 5'h18;

  localparam int CTL_TEN = 0;
  localparam int CTL_CEN = 1;
  localparam int CTL_IEN = 2;
  localparam int CTL_AIN = 3;
  localparam int PRE_LSB = 8;
  localparam int PRE_W   = 8;

  typedef struct packed {
    logic ain;
    logic ien;
    logic cen;
  } bank_ctl_t;
endpackage

// File: rtl/gtm_prescale.sv
module gtm_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] ph_q;

  assign tick = en && (ph_q == div);

  always_ff @(posedge clk) begin
    if (rst || restart || !en) ph_q <= '0;
    else if (ph_q == div)      ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
    ph_q <= div); // R2
endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
  parameter int CNT_W = 64,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [DW-1:0]    wdata,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (lo_we) cnt[DW-1:0] <= wdata;
    else if (hi_we) cnt[CNT_W-1:DW] <= wdata[CNT_W-DW-1:0];
    else if (tick)  cnt <= cnt + 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !lo_we && !hi_we) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !lo_we && !hi_we) |=> $stable(cnt)); // R3
endmodule

// File: rtl/gtm_bank.sv
module gtm_bank
  import gtm_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic [CNT_W-1:0] count,
  input  logic             ctl_we,
  input  logic             st_we,
  input  logic             cmp_lo_we,
  input  logic             cmp_hi_we,
  input  logic             inc_we,
  input  logic [DW-1:0]    wdata,
  output bank_ctl_t        bctl,
  output logic             status,
  output logic [CNT_W-1:0] cmp,
  output logic [DW-1:0]    inc,
  output logic             irq
);
  logic evt;

  assign evt = tmr_en && bctl.cen && (count >= cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      bctl   <= '0;
      status <= 1'b0;
      cmp    <= '0;
      inc    <= '0;
      irq    <= 1'b0;
    end else begin
      if (ctl_we) begin
        bctl.cen <= wdata[CTL_CEN];
        bctl.ien <= wdata[CTL_IEN];
        bctl.ain <= wdata[CTL_AIN];
      end
      if (evt)                  status <= 1'b1;
      else if (st_we && wdata[0]) status <= 1'b0;
      if (cmp_lo_we)      cmp[DW-1:0] <= wdata;
      else if (cmp_hi_we) cmp[CNT_W-1:DW] <= wdata[CNT_W-DW-1:0];
      else if (evt && bctl.ain && (inc != '0))
        cmp <= cmp + CNT_W'(inc);
      if (inc_we) inc <= wdata;
      irq <= status && bctl.ien;
    end
  end

  AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (tmr_en && bctl.cen && (count >= cmp)) |=> status); // R5
  AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (rst)
    (evt && bctl.ain && (inc != '0) && !cmp_lo_we && !cmp_hi_we)
      |=> (cmp == $past(cmp) + CNT_W'($past(inc)))); // R6
  AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(status && bctl.ien)); // R7
endmodule

// File: rtl/glob_cmp_timer.sv
module glob_cmp_timer
  import gtm_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 64,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [CORE_W-1:0]  acc_core,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  output logic [DW-1:0]      acc_rdata,
  output logic               cnt_wr_err,
  output logic [N_CORES-1:0] irq
);
  logic             ten_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             wr, rd, sel_ok;
  logic             ctl_we, cnt_lo_we, cnt_hi_we, cnt_try;

  bank_ctl_t        bctl [N_CORES];
  logic             bst  [N_CORES];
  logic [CNT_W-1:0] bcmp [N_CORES];
  logic [DW-1:0]    binc [N_CORES];

  assign sel_ok    = (int'(acc_core) < N_CORES);
  assign wr        = acc_en && acc_wr;
  assign rd        = acc_en && !acc_wr;
  assign ctl_we    = wr && (acc_addr == OFS_CTL);
  assign cnt_try   = wr && ((acc_addr == OFS_CNT_LO) || (acc_addr == OFS_CNT_HI));
  assign cnt_lo_we = wr && !ten_q && (acc_addr == OFS_CNT_LO);
  assign cnt_hi_we = wr && !ten_q && (acc_addr == OFS_CNT_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      ten_q      <= 1'b0;
      pre_q      <= '0;
      cnt_wr_err <= 1'b0;
    end else begin
      cnt_wr_err <= cnt_try && ten_q;
      if (ctl_we) begin
        ten_q <= acc_wdata[CTL_TEN];
        pre_q <= acc_wdata[PRE_LSB +: PRE_W];
      end
    end
  end

  gtm_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(ten_q), .restart(ctl_we), .div(pre_q), .tick(tick)
  );

  gtm_counter #(.CNT_W(CNT_W), .DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .lo_we(cnt_lo_we), .hi_we(cnt_hi_we),
    .wdata(acc_wdata), .cnt(cnt)
  );

  for (genvar i = 0; i < N_CORES; i++) begin : g_bank
    logic hit;
    assign hit = wr && sel_ok && (int'(acc_core) == i);
    gtm_bank #(.CNT_W(CNT_W), .DW(DW)) u_bank (
      .clk(clk), .rst(rst), .tmr_en(ten_q), .count(cnt),
      .ctl_we(hit && (acc_addr == OFS_CTL)),
      .st_we(hit && (acc_addr == OFS_STAT)),
      .cmp_lo_we(hit && (acc_addr == OFS_CMP_LO)),
      .cmp_hi_we(hit && (acc_addr == OFS_CMP_HI)),
      .inc_we(hit && (acc_addr == OFS_INC)),
      .wdata(acc_wdata),
      .bctl(bctl[i]), .status(bst[i]), .cmp(bcmp[i]), .inc(binc[i]),
      .irq(irq[i])
    );
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    bank_ctl_t        sc;
    logic             ss;
    logic [CNT_W-1:0] sm;
    logic [DW-1:0]    si;
    sc = '0; ss = 1'b0; sm = '0; si = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (sel_ok && (int'(acc_core) == i)) begin
        sc = bctl[i]; ss = bst[i]; sm = bcmp[i]; si = binc[i];
      end
    end
    rd_mux = '0;
    case (acc_addr)
      OFS_CNT_LO: rd_mux = cnt[DW-1:0];
      OFS_CNT_HI: rd_mux = DW'(cnt[CNT_W-1:DW]);
      OFS_CTL: begin
        rd_mux[CTL_TEN]           = ten_q;
        rd_mux[CTL_CEN]           = sc.cen;
        rd_mux[CTL_IEN]           = sc.ien;
        rd_mux[CTL_AIN]           = sc.ain;
        rd_mux[PRE_LSB +: PRE_W]  = pre_q;
      end
      OFS_STAT:   rd_mux[0] = ss;
      OFS_CMP_LO: rd_mux = sm[DW-1:0];
      OFS_CMP_HI: rd_mux = DW'(sm[CNT_W-1:DW]);
      OFS_INC:    rd_mux = si;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_rdata <= '0;
    else if (rd) acc_rdata <= rd_mux;
  end

  AST_LOCKED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ten_q && !tick) |=> $stable(cnt)); // R4
  AST_ERR_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_err |-> $past(ten_q)); // R4
endmodule

// File: tb/test_glob_cmp_timer.sv
module test_glob_cmp_timer;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [1:0]  acc_core = '0;
  logic [4:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        cnt_wr_err;
  logic [N-1:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic last_err;

  always #5 clk = ~clk;

  glob_cmp_timer #(.N_CORES(N)) i_glob_cmp_timer (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_core(acc_core), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .cnt_wr_err(cnt_wr_err), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] c, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_core = c; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    last_err = cnt_wr_err;
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] c, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_core = c; acc_addr = a;
    @(negedge clk);
    d = acc_rdata;
    acc_en = 1'b0;
  endtask

  task automatic tc_reset_state();
    logic [31:0] v;
    bus_rd(0, 5'h00, v); chk("R11 count low after reset", v, 0);
    bus_rd(0, 5'h04, v); chk("R11 count high after reset", v, 0);
    bus_rd(1, 5'h08, v); chk("R11 control after reset", v, 0);
    bus_rd(2, 5'h10, v); chk("R11 comparator after reset", v, 0);
    chk("R11 irq after reset", irq, 0);
    bus_rd(0, 5'h1C, v); chk("R10 unmapped offset reads zero", v, 0);
  endtask

  task automatic tc_counting();
    logic [31:0] a, b;
    bus_wr(0, 5'h00, 32'h10); chk("R4 no error when stopped", last_err, 0);
    bus_wr(0, 5'h04, 32'h2);
    bus_rd(0, 5'h00, a); chk("R1 low half readback", a, 32'h10);
    bus_rd(0, 5'h04, a); chk("R1 high half readback", a, 32'h2);
    bus_wr(0, 5'h08, 32'h0301);
    bus_rd(0, 5'h00, a);
    repeat (39) @(negedge clk);
    bus_rd(0, 5'h00, b);
    chk("R2 ten steps in forty cycles at P=3", b - a, 10);
    bus_wr(0, 5'h04, 32'h5); chk("R4 error pulse on running load", last_err, 1);
    bus_rd(0, 5'h04, a); chk("R4 high half not loaded", a, 32'h2);
    bus_wr(0, 5'h08, 32'h0);
    bus_rd(0, 5'h00, a);
    repeat (20) @(negedge clk);
    bus_rd(0, 5'h00, b);
    chk("R3 count holds while stopped", b, a);
  endtask

  task automatic tc_compare();
    logic [31:0] v;
    bus_wr(0, 5'h00, 32'd100);
    bus_wr(0, 5'h04, 32'd0);
    bus_wr(0, 5'h10, 32'd150);
    bus_wr(0, 5'h08, 32'h6);
    bus_wr(1, 5'h08, 32'h2);
    bus_wr(0, 5'h08, 32'hFF07);
    repeat (4) @(negedge clk);
    chk("R7 no irq without enable or event", irq, 4'b0000);
    bus_rd(1, 5'h0C, v); chk("R5 core1 event sets status", v, 1);
    bus_rd(0, 5'h0C, v); chk("R5 no event below comparator", v, 0);
    bus_wr(0, 5'h10, 32'd100);
    repeat (4) @(negedge clk);
    bus_rd(0, 5'h0C, v); chk("R5 event at equal value", v, 1);
    chk("R7 only core0 irq", irq, 4'b0001);
    bus_wr(0, 5'h0C, 32'h0);
    bus_rd(0, 5'h0C, v); chk("R8 writing zero keeps status", v, 1);
    bus_wr(0, 5'h08, 32'hFF05);
    bus_wr(0, 5'h0C, 32'h1);
    repeat (3) @(negedge clk);
    bus_rd(0, 5'h0C, v); chk("R8 write one clears status", v, 0);
    chk("R7 irq drops after clear", irq, 4'b0000);
    bus_rd(0, 5'h08, v); chk("R9 core0 control merge", v, 32'hFF05);
    bus_rd(1, 5'h08, v); chk("R9 core1 control merge", v, 32'hFF03);
  endtask

  task automatic tc_autoinc();
    logic [31:0] v;
    bus_wr(2, 5'h08, 32'h0);
    bus_wr(2, 5'h00, 32'd1000);
    bus_wr(2, 5'h10, 32'd990);
    bus_wr(2, 5'h18, 32'd7);
    bus_wr(3, 5'h10, 32'd995);
    bus_wr(3, 5'h08, 32'hA);
    bus_wr(2, 5'h08, 32'hFF0B);
    repeat (8) @(negedge clk);
    bus_rd(2, 5'h10, v); chk("R6 comparator settles at 1004", v, 32'd1004);
    bus_rd(2, 5'h14, v); chk("R6 comparator high unchanged", v, 0);
    bus_rd(2, 5'h0C, v); chk("R5 core2 status set", v, 1);
    bus_rd(3, 5'h10, v); chk("R6 zero increment leaves comparator", v, 32'd995);
    bus_rd(2, 5'h18, v); chk("R6 increment readback", v, 32'd7);
  endtask

  task automatic tc_late_reset();
    logic [31:0] v;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    bus_rd(0, 5'h00, v); chk("R11 count cleared", v, 0);
    bus_rd(2, 5'h10, v); chk("R11 comparator cleared", v, 0);
    bus_rd(2, 5'h0C, v); chk("R11 status cleared", v, 0);
    chk("R11 irq cleared", irq, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tc_reset_state();
    tc_counting();
    tc_compare();
    tc_autoinc();
    tc_late_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule